// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A single-cycle start request makes it drive the sample/hold control for a set number of cycles and then release it into hold. It then works out an N-bit code, one bit per step, starting at the most significant bit. In each step it presents a trial code to an external DAC. It waits a programmable settle time and then reads a single comparator bit, which tells it whether the held input is at or above the trial level. The DAC, the comparator and the sample/hold sit outside the block and are seen only as ports.

The comparator bit is asynchronous to the block. It passes through a two-flop synchronizer, and the settle count is long enough to cover that delay. Every conversion takes the same number of cycles whatever the input. When the last bit is settled, a one-cycle done pulse marks the new result. The result register keeps that value until the next conversion finishes.

Top module: `sar_adc_seq`

## Requirements
- R1: While reset is asserted and after its release, sample_o, busy_o and done_o are 0, and dac_code_o and result_o are all zeros.
- R2: When go_i is seen high at a clock edge while idle, sample_o is high for exactly SAMPLE_CYCLES cycles, starting the next cycle. During those cycles dac_code_o is all zeros.
- R3: In the cycle after sample_o falls, dac_code_o equals the MSB alone (1 << (N_BITS-1)). Bits are tested from MSB down to LSB.
- R4: Each trial code is held on dac_code_o for SETTLE_CYCLES cycles (3 or more). The next trial code keeps the bits already decided, sets the next lower bit and leaves the bits below it at 0.
- R5: cmp_i = 1 means the held input is at or above the trial level, and the bit under test is kept. cmp_i = 0 clears it. The decision uses the value of cmp_i captured two clock edges before the last edge of the step. The final code is therefore floor(input / LSB), limited to the full-scale code.
- R6: done_o rises exactly SAMPLE_CYCLES + N_BITS*SETTLE_CYCLES clock edges after the edge that accepted go_i, whatever the input.
- R7: done_o is a one-cycle pulse. result_o takes the final code at the same edge that raises done_o, and it changes at no other edge.
- R8: go_i is ignored while busy_o is high: the conversion in progress keeps its timing and its result.
- R9: With 3 bits and an input between 2 LSB and 3 LSB, the result is 010.
- R10: busy_o is high from the first sample cycle through the last bit step, and it is low in the cycle done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, seen while idle |
| cmp_i | input | 1 | Comparator decision, 1 = held input at or above DAC level (asynchronous) |
| sample_o | output | 1 | Sample/hold control, 1 = track, 0 = hold |
| busy_o | output | 1 | Conversion in progress |
| dac_code_o | output | N_BITS | Trial code to the DAC |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | N_BITS | Last completed conversion code |

## Verification
A wrong step counter or settle counter in this block shows at the ports as a trial code that changes a cycle early or late. It also moves done_o away from its fixed cycle. A per-cycle reference model catches this on the first cycle it differs. A mistake in the code or mask register makes a wrong trial pattern appear on dac_code_o in the very next step, well before a wrong result would reach result_o. If the synchronizer depth or the settle timing is wrong, decisions are made on a stale comparator value. The inputs that show this sit right at a trial level, so exact-boundary and full-scale values are driven on purpose.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int N_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              keep_i,
  output logic [N_BITS-1:0] code_o,
  output logic [N_BITS-1:0] settled_o,
  output logic              last_o
);
  localparam logic [N_BITS-1:0] MSB = {1'b1, {(N_BITS-1){1'b0}}};

  logic [N_BITS-1:0] code_q, mask_q;

  // code with the bit under test resolved, lower bits still zero
  assign settled_o = keep_i ? code_q : (code_q & ~mask_q);
  assign last_o    = mask_q[0];
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (clear_i) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      code_q <= MSB;
      mask_q <= MSB;
    end else if (step_i) begin
      code_q <= settled_o | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int N_BITS        = 8,
  parameter int SAMPLE_CYCLES = 4,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              cmp_i,
  output logic              sample_o,
  output logic              busy_o,
  output logic [N_BITS-1:0] dac_code_o,
  output logic              done_o,
  output logic [N_BITS-1:0] result_o
);
  import sar_pkg::*;

  // settle must cover the two synchronizer flops plus one cycle of DAC output
  localparam int S_EFF = (SAMPLE_CYCLES < 1) ? 1 : SAMPLE_CYCLES;
  localparam int T_EFF = (SETTLE_CYCLES < 3) ? 3 : SETTLE_CYCLES;
  localparam int MAXC  = (S_EFF > T_EFF) ? S_EFF : T_EFF;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] S_LOAD = CW'(S_EFF - 1);
  localparam logic [CW-1:0] T_LOAD = CW'(T_EFF - 1);

  sar_state_e        st_q, st_d;
  logic              cmp_s, zero, last;
  logic              tmr_load, reg_clear, reg_start, reg_step;
  logic [CW-1:0]     tmr_val;
  logic [N_BITS-1:0] code, settled;
  logic              done_q;
  logic [N_BITS-1:0] result_q;

  sar_sync u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cmp_i), .q_o (cmp_s)
  );

  sar_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load),
    .load_val_i (tmr_val), .zero_o (zero)
  );

  sar_reg #(.N_BITS(N_BITS)) u_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (reg_clear),
    .start_i (reg_start), .step_i (reg_step), .keep_i (cmp_s),
    .code_o (code), .settled_o (settled), .last_o (last)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = T_LOAD;
    reg_clear = 1'b0;
    reg_start = 1'b0;
    reg_step  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_i) begin
        st_d      = ST_SAMPLE;
        tmr_load  = 1'b1;
        tmr_val   = S_LOAD;
        reg_clear = 1'b1;
      end
      ST_SAMPLE: if (zero) begin
        st_d      = ST_TRIAL;
        tmr_load  = 1'b1;
        reg_start = 1'b1;
      end
      ST_TRIAL: if (zero) begin
        reg_step = 1'b1;
        if (last) st_d = ST_IDLE;
        else      tmr_load = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= reg_step && last;
      if (reg_step && last) result_q <= settled;
    end
  end

  assign sample_o   = (st_q == ST_SAMPLE);
  assign busy_o     = (st_q != ST_IDLE);
  assign dac_code_o = code;
  assign done_o     = done_q;
  assign result_o   = result_q;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int N_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_o,
  input logic              busy_o,
  input logic [N_BITS-1:0] dac_code_o,
  input logic              done_o,
  input logic [N_BITS-1:0] result_o
);
  localparam logic [N_BITS-1:0] MSB = {1'b1, {(N_BITS-1){1'b0}}};

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_o || $stable(result_o)));

  p_dac_clear_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (dac_code_o == '0));

  p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> (dac_code_o == MSB));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_sample_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o);

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sample_o) |=> !sample_o);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_o   (sample_o),
  .busy_o     (busy_o),
  .dac_code_o (dac_code_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int S = 4;
  localparam int T = 4;
  localparam int FULL = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, cmp = 1'b0;
  logic sample, busy, done;
  logic [N-1:0] dac, result;

  logic go3 = 1'b0, cmp3 = 1'b0;
  logic sample3, busy3, done3;
  logic [2:0] dac3, result3;

  int vin_x2 = 0;   // held input in half-LSB units
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_adc_seq #(.N_BITS(N), .SAMPLE_CYCLES(S), .SETTLE_CYCLES(T)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .go_i (go), .cmp_i (cmp),
    .sample_o (sample), .busy_o (busy), .dac_code_o (dac),
    .done_o (done), .result_o (result)
  );

  sar_adc_seq #(.N_BITS(3), .SAMPLE_CYCLES(2), .SETTLE_CYCLES(3)) u_dut3 (
    .clk_i (clk), .rst_ni (rst_n), .go_i (go3), .cmp_i (cmp3),
    .sample_o (sample3), .busy_o (busy3), .dac_code_o (dac3),
    .done_o (done3), .result_o (result3)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_bit = 0, m_code = 0, m_res = 0, g_cyc = 0;
  bit m_done = 0, m_s1 = 0, m_s2 = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      m_done = 0;
      if (m_st == 0) begin
        if (go) begin m_st = 1; m_cnt = S - 1; m_code = 0; g_cyc = cyc; end
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin m_st = 2; m_bit = N - 1; m_code = 1 << (N - 1); m_cnt = T - 1; end
        else m_cnt--;
      end else begin
        if (m_cnt == 0) begin
          if (!m_s2) m_code &= ~(1 << m_bit);
          if (m_bit == 0) begin
            m_st = 0; m_done = 1; m_res = m_code;
            chk((cyc - g_cyc) == S + N*T, "R6 conversion length", cyc - g_cyc, S + N*T);
          end else begin
            m_bit--; m_code |= (1 << m_bit); m_cnt = T - 1;
          end
        end else m_cnt--;
      end
      m_s2 = m_s1;
      m_s1 = cmp;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sample === (m_st == 1), "R2 sample_o", int'(sample), int'(m_st == 1));
      chk(busy === (m_st != 0), "R10 busy_o", int'(busy), int'(m_st != 0));
      chk(dac === N'(m_code), "R4 dac_code_o", int'(dac), m_code);
      chk(done === m_done, "R7 done_o", int'(done), int'(m_done));
      chk(result === N'(m_res), "R7 result_o", int'(result), m_res);
    end
    cmp  <= (vin_x2 >= 2 * int'(dac));
    cmp3 <= (5 >= 2 * int'(dac3));   // 2.5 LSB
  end

  task automatic convert(input int vx2, input bit poke_go);
    int exp, n;
    vin_x2 = vx2;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
      if (poke_go && n == 20) go = 1'b1;   // R8: start request mid-conversion
      if (poke_go && n == 22) go = 1'b0;
    end
    exp = vx2 / 2;
    if (exp > FULL) exp = FULL;
    chk(done === 1'b1, "R6 done seen", int'(done), 1);
    chk(result === N'(exp), "R5 final code", int'(result), exp);
    repeat (3) @(negedge clk);
    chk(result === N'(exp), "R7 result held", int'(result), exp);
    chk(busy === 1'b0, "R8 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sample === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset controls",
        int'({sample, busy, done}), 0);
    chk(dac === '0 && result === '0, "R1 reset codes", int'(dac) + int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample === 1'b0 && dac === '0, "R1 after release", int'(dac), 0);

    // R9 on the 3-bit instance
    go3 = 1'b1; @(negedge clk); go3 = 1'b0;
    for (int i = 0; i < 40 && !done3; i++) @(negedge clk);
    chk(done3 === 1'b1, "R9 done", int'(done3), 1);
    chk(result3 === 3'b010, "R9 code", int'(result3), 2);

    convert(0, 1'b0);            // zero scale
    convert(2*FULL + 1, 1'b0);   // full scale
    convert(256, 1'b0);          // exactly at MSB level (R5 boundary)
    convert(255, 1'b0);          // half LSB below MSB level
    convert(171, 1'b1);          // 85.5 LSB with go poked mid-way (R8)
    convert(2*170, 1'b0);        // alternating pattern
    convert(3, 1'b0);            // 1.5 LSB (R3 low bits)

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d expected finish earlier", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule